// File: doc/BRIEF.md
# Serial Configuration Register Port for a Panel Timing Controller

This block is the configuration port of a display timing controller. An external host reaches it over a three-wire serial link: an active-low select, a serial clock and a serial data input, plus a serial data output that the block drives only while it is returning read data. Every transaction is a 14-bit frame. The frame carries a direction bit, a 5-bit address that picks one of 32 byte-wide registers, and one data byte. Writes update the register file. Reads return the addressed byte, most significant bit first.

The block runs entirely on the chip's core clock. It oversamples the three serial inputs through a synchronizer and detects the serial clock edges in the core domain, so the serial clock must be several times slower than the core clock. Two registers configure the rest of the controller. The first selects the video input interface and the panel resolution. The second holds the scan directions, the colour order of even lines on delta panels and the half-dot phase of even lines. Each group has an override bit. When that bit is set, the settings come from the board strap pins instead of the register fields. The remaining addresses are plain byte storage.

Top module: `tcon_cfg_port`

## Requirements
- R1: A frame begins when `cs_n` goes low. The block takes `sdi` on each rising edge of `sclk`. The first bit is the direction (0 = write, 1 = read). The next five bits are the address, most significant bit first. The last eight bits are the data byte, most significant bit first.
- R2: A write takes effect only after the 14th rising `sclk` edge. If `cs_n` returns high before that edge, no register changes.
- R3: In a read frame the block drives the addressed byte on `sdo`, most significant bit first. It changes `sdo` after each falling `sclk` edge, starting with the falling edge that follows the sixth rising edge. The host can therefore sample data bit k on rising edge 6+k.
- R4: `sdo_oe` is 1 only during the data phase of a read frame. It is 0 while `cs_n` is high, during the header of any frame and during every write frame.
- R5: While `rst_n` is low, all 32 registers clear to zero and `sdo_oe` goes to 0. An address that has never been written reads back as 0x00.
- R6: Register 0 holds three fields. Bit 0 is the strap override for the interface and resolution settings. Bits 3:1 are the interface code and bits 6:4 are the resolution code. When bit 0 is 1, `cfg_if` and `cfg_res` follow `pin_if` and `pin_res`. When bit 0 is 0, they follow the register fields.
- R7: Register 1 holds the scan settings. Bit 0 is the strap override, bit 1 is the up/down direction and bit 2 is the left/right direction. When bit 0 is 1, `cfg_ud` and `cfg_lr` follow `pin_ud` and `pin_lr`. When bit 0 is 0, they follow bits 1 and 2.
- R8: `cfg_even_gbr` reflects register 1 bit 3. A value of 1 means even delta lines arrive in G-B-R order and 0 means B-R-G order. Odd lines are always R-G-B.
- R9: Register 1 bits 5:4 set the even-line phase. A value of 00 asserts only `cfg_even_lag`, meaning even lines lag odd lines by half a dot. A value of 01 asserts only `cfg_even_lead`. A value of 10 or 11 asserts neither, meaning the lines are in phase.
- R10: Clock bits after the 14th in the same frame are ignored. They cause no second write and do not change the stored byte.
- R11: Every one of the 32 addresses stores a full byte and returns it on a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means the pad is high impedance |
| pin_if | input | 3 | Interface code from the strap pins |
| pin_res | input | 3 | Resolution code from the strap pins |
| pin_ud | input | 1 | Up/down scan strap |
| pin_lr | input | 1 | Left/right scan strap |
| cfg_if | output | 3 | Effective interface code |
| cfg_res | output | 3 | Effective resolution code |
| cfg_ud | output | 1 | Effective up/down scan direction |
| cfg_lr | output | 1 | Effective left/right scan direction |
| cfg_even_gbr | output | 1 | Even delta lines in G-B-R order (0 = B-R-G) |
| cfg_even_lead | output | 1 | Even line leads by half a dot |
| cfg_even_lag | output | 1 | Even line lags by half a dot |

## Verification
A bit counter that is off by one shifts every address and data field. Such a fault shows up on the first read-back as a byte rotated by one position, or as a write that lands in a neighbouring register, within a single frame of the fault. A counter that is not cleared by the select input shows up in the next frame after an aborted one: the aborted write either commits or corrupts a later access. A wrong override or phase decode is visible on the `cfg_*` outputs a few core cycles after the select goes high, and the strap pins are set to values that differ from the register fields so such a fault cannot hide. Enable faults are caught at every sampled data bit, because `sdo_oe` is checked during both read and write frames.

// File: rtl/tcon_cfg_pkg.sv
package tcon_cfg_pkg;

    localparam int CFG_ADDR_W  = 5;
    localparam int CFG_DATA_W  = 8;
    localparam int CFG_SYNC_N  = 2;

    // register addresses with decoded meaning
    localparam int REG_IFRES   = 0;
    localparam int REG_SCAN    = 1;

    // register 0 layout
    localparam int IFRES_EXT   = 0;
    localparam int IFRES_IF_LO = 1;
    localparam int IFRES_RS_LO = 4;
    localparam int CODE_W      = 3;

    // register 1 layout
    localparam int SCAN_EXT    = 0;
    localparam int SCAN_UD     = 1;
    localparam int SCAN_LR     = 2;
    localparam int SCAN_GBR    = 3;
    localparam int SCAN_PH_LO  = 4;

    typedef enum logic [1:0] {
        PH_EVEN_LAG  = 2'b00,
        PH_EVEN_LEAD = 2'b01,
        PH_SAME_A    = 2'b10,
        PH_SAME_B    = 2'b11
    } phase_e;

endpackage

// File: rtl/tcon_cfg_sync.sv
module tcon_cfg_sync #(
    parameter int STAGES = tcon_cfg_pkg::CFG_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);

    typedef struct packed {
        logic [STAGES-1:0] cs_p;
        logic [STAGES-1:0] ck_p;
        logic [STAGES-1:0] di_p;
        logic              ck_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.cs_p    = {s_q.cs_p[STAGES-2:0], cs_n};
        s_d.ck_p    = {s_q.ck_p[STAGES-2:0], sclk};
        s_d.di_p    = {s_q.di_p[STAGES-2:0], sdi};
        s_d.ck_last = s_q.ck_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cs_p    <= '1;
            s_q.ck_p    <= '0;
            s_q.di_p    <= '0;
            s_q.ck_last <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_act    = ~s_q.cs_p[STAGES-1];
    assign sclk_rise =  s_q.ck_p[STAGES-1] & ~s_q.ck_last;
    assign sclk_fall = ~s_q.ck_p[STAGES-1] &  s_q.ck_last;
    assign sdi_s     =  s_q.di_p[STAGES-1];

endmodule

// File: rtl/tcon_cfg_frame.sv
module tcon_cfg_frame #(
    parameter int ADDR_W = tcon_cfg_pkg::CFG_ADDR_W,
    parameter int DATA_W = tcon_cfg_pkg::CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              rnw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wsh;
        logic [DATA_W-1:0] rsh;
        logic              sdo;
        logic              oe;
        logic              wr;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        f_d.wr = 1'b0;
        if (!cs_act) begin
            f_d.cnt = '0;
            f_d.rnw = 1'b0;
            f_d.oe  = 1'b0;
            f_d.sdo = 1'b0;
        end else begin
            // capture path: rising serial clock
            if (sclk_rise && (f_q.cnt != CNT_FULL)) begin
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == '0) begin
                    f_d.rnw = sdi_s;
                end else if (f_q.cnt <= CNT_ADDR) begin
                    f_d.addr = {f_q.addr[ADDR_W-2:0], sdi_s};
                end else begin
                    f_d.wsh = {f_q.wsh[DATA_W-2:0], sdi_s};
                end
                if ((f_q.cnt == CNT_LAST) && !f_q.rnw) begin
                    f_d.wr = 1'b1;
                end
            end
            // launch path: falling serial clock
            if (sclk_fall && f_q.rnw) begin
                if (f_q.cnt == CNT_HDR) begin
                    f_d.sdo = rd_data[DATA_W-1];
                    f_d.rsh = {rd_data[DATA_W-2:0], 1'b0};
                    f_d.oe  = 1'b1;
                end else if ((f_q.cnt > CNT_HDR) && (f_q.cnt < CNT_FULL)) begin
                    f_d.sdo = f_q.rsh[DATA_W-1];
                    f_d.rsh = {f_q.rsh[DATA_W-2:0], 1'b0};
                end else if (f_q.cnt == CNT_FULL) begin
                    f_d.oe  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign addr    = f_q.addr;
    assign wr_en   = f_q.wr;
    assign wr_data = f_q.wsh;
    assign sdo     = f_q.sdo;
    assign sdo_oe  = f_q.oe;

endmodule

// File: rtl/tcon_cfg_regs.sv
module tcon_cfg_regs #(
    parameter int ADDR_W = tcon_cfg_pkg::CFG_ADDR_W,
    parameter int DATA_W = tcon_cfg_pkg::CFG_DATA_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [NUM_REGS-1:0][DATA_W-1:0] mem_d, mem_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                mem_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign regs    = mem_q;

endmodule

// File: rtl/tcon_cfg_mux.sv
module tcon_cfg_mux
    import tcon_cfg_pkg::*;
#(
    parameter int DATA_W = CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] reg_ifres,
    input  logic [DATA_W-1:0] reg_scan,
    input  logic [CODE_W-1:0] pin_if,
    input  logic [CODE_W-1:0] pin_res,
    input  logic              pin_ud,
    input  logic              pin_lr,
    output logic [CODE_W-1:0] cfg_if,
    output logic [CODE_W-1:0] cfg_res,
    output logic              cfg_ud,
    output logic              cfg_lr,
    output logic              cfg_even_gbr,
    output logic              cfg_even_lead,
    output logic              cfg_even_lag
);

    typedef struct packed {
        logic [CODE_W-1:0] if_code;
        logic [CODE_W-1:0] res_code;
        logic              ud;
        logic              lr;
        logic              gbr;
        logic              lead;
        logic              lag;
    } eff_t;

    eff_t e_d, e_q;
    phase_e ph;

    always_comb begin
        ph = phase_e'(reg_scan[SCAN_PH_LO +: 2]);
        e_d = '0;
        if (reg_ifres[IFRES_EXT]) begin
            e_d.if_code  = pin_if;
            e_d.res_code = pin_res;
        end else begin
            e_d.if_code  = reg_ifres[IFRES_IF_LO +: CODE_W];
            e_d.res_code = reg_ifres[IFRES_RS_LO +: CODE_W];
        end
        if (reg_scan[SCAN_EXT]) begin
            e_d.ud = pin_ud;
            e_d.lr = pin_lr;
        end else begin
            e_d.ud = reg_scan[SCAN_UD];
            e_d.lr = reg_scan[SCAN_LR];
        end
        e_d.gbr = reg_scan[SCAN_GBR];
        case (ph)
            PH_EVEN_LAG:  e_d.lag  = 1'b1;
            PH_EVEN_LEAD: e_d.lead = 1'b1;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign cfg_if        = e_q.if_code;
    assign cfg_res       = e_q.res_code;
    assign cfg_ud        = e_q.ud;
    assign cfg_lr        = e_q.lr;
    assign cfg_even_gbr  = e_q.gbr;
    assign cfg_even_lead = e_q.lead;
    assign cfg_even_lag  = e_q.lag;

endmodule

// File: rtl/tcon_cfg_port.sv
module tcon_cfg_port
    import tcon_cfg_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int DATA_W = CFG_DATA_W,
    parameter int SYNC_N = CFG_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [CODE_W-1:0] pin_if,
    input  logic [CODE_W-1:0] pin_res,
    input  logic              pin_ud,
    input  logic              pin_lr,
    output logic [CODE_W-1:0] cfg_if,
    output logic [CODE_W-1:0] cfg_res,
    output logic              cfg_ud,
    output logic              cfg_lr,
    output logic              cfg_even_gbr,
    output logic              cfg_even_lead,
    output logic              cfg_even_lag
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic                            cs_act;
    logic                            sclk_rise;
    logic                            sclk_fall;
    logic                            sdi_s;
    logic [ADDR_W-1:0]               fr_addr;
    logic                            wr_en;
    logic [DATA_W-1:0]               wr_data;
    logic [DATA_W-1:0]               rd_data;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    tcon_cfg_sync #(
        .STAGES (SYNC_N)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s)
    );

    tcon_cfg_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .addr      (fr_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    tcon_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (fr_addr),
        .wr_data (wr_data),
        .rd_addr (fr_addr),
        .rd_data (rd_data),
        .regs    (regs)
    );

    tcon_cfg_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_ifres     (regs[REG_IFRES]),
        .reg_scan      (regs[REG_SCAN]),
        .pin_if        (pin_if),
        .pin_res       (pin_res),
        .pin_ud        (pin_ud),
        .pin_lr        (pin_lr),
        .cfg_if        (cfg_if),
        .cfg_res       (cfg_res),
        .cfg_ud        (cfg_ud),
        .cfg_lr        (cfg_lr),
        .cfg_even_gbr  (cfg_even_gbr),
        .cfg_even_lead (cfg_even_lead),
        .cfg_even_lag  (cfg_even_lag)
    );

endmodule

// File: rtl/tcon_cfg_port_chk.sv
module tcon_cfg_port_chk #(
    parameter int ADDR_W = tcon_cfg_pkg::CFG_ADDR_W,
    parameter int DATA_W = tcon_cfg_pkg::CFG_DATA_W
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               cs_act,
    input logic                               sclk_fall,
    input logic                               sdo,
    input logic                               sdo_oe,
    input logic                               wr_en,
    input logic [ADDR_W-1:0]                  fr_addr,
    input logic [DATA_W-1:0]                  wr_data,
    input logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs,
    input logic [2:0]                         pin_if,
    input logic [2:0]                         cfg_if,
    input logic                               cfg_even_lead,
    input logic                               cfg_even_lag
);

    // R4: enable drops once the select is released
    a_r4_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);

    // R3: read data moves only after a falling serial clock
    a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !sclk_fall) |=> $stable(sdo));

    // R10: at most one commit per frame
    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R11: the committed byte is stored at the frame's address
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(fr_addr)] == $past(wr_data)));

    // R6: override bit routes the strap code to the output
    a_r6_strap_follow: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0][0] |=> (cfg_if == $past(pin_if)));

    // R9: lead and lag never both set
    a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_even_lead, cfg_even_lag}));

endmodule

bind tcon_cfg_port tcon_cfg_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_act        (cs_act),
    .sclk_fall     (sclk_fall),
    .sdo           (sdo),
    .sdo_oe        (sdo_oe),
    .wr_en         (wr_en),
    .fr_addr       (fr_addr),
    .wr_data       (wr_data),
    .regs          (regs),
    .pin_if        (pin_if),
    .cfg_if        (cfg_if),
    .cfg_even_lead (cfg_even_lead),
    .cfg_even_lag  (cfg_even_lag)
);

// File: tb/tcon_cfg_port_test.sv
module tcon_cfg_port_test;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, sclk, sdi;
    logic       sdo, sdo_oe;
    logic [2:0] pin_if, pin_res;
    logic       pin_ud, pin_lr;
    logic [2:0] cfg_if, cfg_res;
    logic       cfg_ud, cfg_lr, cfg_even_gbr, cfg_even_lead, cfg_even_lag;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] model [32];
    logic [7:0] expq [$];

    always #4 clk = ~clk;

    tcon_cfg_port uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe),
        .pin_if (pin_if), .pin_res (pin_res), .pin_ud (pin_ud), .pin_lr (pin_lr),
        .cfg_if (cfg_if), .cfg_res (cfg_res), .cfg_ud (cfg_ud), .cfg_lr (cfg_lr),
        .cfg_even_gbr (cfg_even_gbr), .cfg_even_lead (cfg_even_lead),
        .cfg_even_lag (cfg_even_lag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: sends a frame of nbits and predicts its effect
    task automatic frame(input bit rnw, input bit [4:0] a, input bit [7:0] d, input int nbits);
        logic [13:0] f;
        f = {rnw, a, d};
        if (nbits >= 14) begin
            if (rnw) expq.push_back(model[a]);
            else     model[a] = d;
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 14) ? f[13-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr(input bit [4:0] a, input bit [7:0] d);
        frame(1'b0, a, d, 14);
    endtask

    task automatic rd(input bit [4:0] a);
        frame(1'b1, a, 8'h00, 14);
    endtask

    // monitor: samples sdo where the host would and scores read bytes
    initial begin : monitor
        int         pos;
        logic       r;
        logic       oe_ok;
        logic [7:0] got;
        logic [7:0] exp;
        pos = 0; r = 1'b0; oe_ok = 1'b1; got = '0;
        forever begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) begin
                pos = 0;
            end else begin
                if (pos == 0) begin
                    r = sdi; oe_ok = 1'b1; got = '0;
                end else if (pos >= 6 && pos < 14) begin
                    got = {got[6:0], sdo};
                    if (r) oe_ok = oe_ok & sdo_oe;
                    else   check("R4 enable low in write frame", sdo_oe, 0);
                    if (pos == 13 && r) begin
                        if (expq.size() == 0) begin
                            check("R3 unexpected read", 1, 0);
                        end else begin
                            exp = expq.pop_front();
                            check("R3 R1 read byte", got, exp);
                            check("R4 enable high during read", oe_ok, 1);
                        end
                    end
                end else if (pos < 6) begin
                    check("R4 enable low in header", sdo_oe, 0);
                end
                pos++;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
        pin_if = 3'd2; pin_res = 3'd7; pin_ud = 1'b1; pin_lr = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 reset state
        check("R5 oe after reset", sdo_oe, 0);
        check("R5 R6 if after reset", cfg_if, 0);
        check("R5 R6 res after reset", cfg_res, 0);
        check("R5 R7 ud after reset", cfg_ud, 0);
        check("R5 R9 lag after reset", cfg_even_lag, 1);
        check("R5 R9 lead after reset", cfg_even_lead, 0);

        // R6 register fields
        wr(5'd0, 8'h6A);
        check("R6 if from register", cfg_if, 5);
        check("R6 res from register", cfg_res, 6);
        // R6 strap override
        wr(5'd0, 8'h6B);
        check("R6 if from straps", cfg_if, 2);
        check("R6 res from straps", cfg_res, 7);
        pin_if = 3'd4; pin_res = 3'd1;
        repeat (3) @(negedge clk);
        check("R6 if tracks straps", cfg_if, 4);
        check("R6 res tracks straps", cfg_res, 1);

        // R7 R8 R9 scan register
        pin_ud = 1'b0; pin_lr = 1'b1;
        wr(5'd1, 8'h1A);
        check("R7 ud from register", cfg_ud, 1);
        check("R7 lr from register", cfg_lr, 0);
        check("R8 even order gbr", cfg_even_gbr, 1);
        check("R9 phase 01 lead", cfg_even_lead, 1);
        check("R9 phase 01 lag", cfg_even_lag, 0);
        wr(5'd1, 8'h1B);
        check("R7 ud from strap", cfg_ud, 0);
        check("R7 lr from strap", cfg_lr, 1);
        wr(5'd1, 8'h22);
        check("R8 even order brg", cfg_even_gbr, 0);
        check("R9 phase 10 lead", cfg_even_lead, 0);
        check("R9 phase 10 lag", cfg_even_lag, 0);
        wr(5'd1, 8'h34);
        check("R7 lr register bit", cfg_lr, 1);
        check("R9 phase 11 lead", cfg_even_lead, 0);
        check("R9 phase 11 lag", cfg_even_lag, 0);
        wr(5'd1, 8'h04);
        check("R9 phase 00 lag", cfg_even_lag, 1);

        // R1 R3 read back decoded registers
        rd(5'd0);
        rd(5'd1);
        check("R4 enable low after read", sdo_oe, 0);

        // R11 storage at far addresses
        wr(5'd31, 8'hA5);
        wr(5'd17, 8'h3C);
        rd(5'd31);
        rd(5'd17);

        // R2 aborted writes leave storage unchanged
        frame(1'b0, 5'd17, 8'hFF, 10);
        frame(1'b0, 5'd17, 8'hFF, 13);
        rd(5'd17);
        frame(1'b0, 5'd0, 8'h00, 13);
        check("R2 aborted write keeps override", cfg_if, 4);

        // R10 bits past the frame are ignored
        frame(1'b0, 5'd5, 8'h81, 16);
        rd(5'd5);
        rd(5'd17);

        // R5 never-written address reads zero
        rd(5'd9);

        repeat (20) @(negedge clk);
        check("R3 all reads observed", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule